// File: doc/BRIEF.md
# Ancillary Data Dual-Clock FIFO

This block buffers ancillary words taken from a video stream. The words are written at the video clock rate and read back in an unrelated read-clock domain. It holds 1024 words of 10 bits. Both enables are active low. One active-low reset, sampled on the write clock, returns both pointers to their starting positions. The reset must be held for at least six write-clock cycles and at least four read-clock cycles, so that every synchroniser is flushed.

Fill state is reported as one 3-bit code, registered in the write-clock domain. The code covers the normal levels from empty to full and two sticky error codes. One error code marks a read attempted while the FIFO is empty. The other marks a write attempted while it is full. After an overflow no further words are accepted until the reset is applied. A read is seen by the status through a two-flop crossing plus the status register, which is three write-clock cycles. A write is seen on the next write-clock edge.

Top module: `ancFifo`

## Requirements
- R1: After reset, fillCode is 3'b001 (empty) and rdData is 0.
- R2: Words come out of rdData in the order they were accepted. Each rdClk edge with rdEnN low and the FIFO not empty presents the next word on rdData after that edge.
- R3: A wrClk edge with wrEnN high stores nothing, and the write pointer holds.
- R4: A rdClk edge with rdEnN high leaves rdData unchanged, and the read pointer holds.
- R5: With L words held, fillCode is 3'b001 for L=0, 3'b010 for 1..32 and 3'b011 for 33..511.
- R6: fillCode is 3'b100 for L=512..991, 3'b101 for L=992..1023 and 3'b110 for L=1024.
- R7: A write attempted while full drops the word and sets fillCode to 3'b111. The code stays 3'b111 and no word is accepted until reset. The code can only become 3'b111 after a write attempt.
- R8: A read attempted while empty leaves rdData unchanged and sets fillCode to 3'b000. The code stays 3'b000 until reset, even after later writes.
- R9: When both error conditions have occurred, fillCode shows 3'b111.
- R10: After reset, old contents are discarded. The first word written after reset is the first word read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Video (write) clock |
| fifoRstN | input | 1 | Active-low pointer reset, sampled on wrClk |
| wrEnN | input | 1 | Active-low write enable |
| wrData | input | 10 | Word to store |
| rdClk | input | 1 | Read clock |
| rdEnN | input | 1 | Active-low read enable |
| rdData | output | 10 | Word last read |
| fillCode | output | 3 | Encoded fill and error status |

## Verification
The FIFO is filled from reset one step at a time, so that every threshold edge of the status code is crossed: 0/1, 32/33, 511/512, 991/992, 1023/1024. This separates off-by-one errors in each comparison. Idle cycles on each enable, driven with changing data, show whether the pointers really hold. A complete drain of 1024 words after an overflow attempt shows that the extra word was dropped and that order was kept. Underflow on an empty FIFO, followed by writes, shows the error code is sticky. Combining overflow and underflow shows the priority between the two.

// File: rtl/ancFifoPkg.sv
package ancFifoPkg;
  parameter int ADDR_W = 10;
  parameter int PTR_W = ADDR_W + 1;

  typedef enum logic [2:0] {
    FILL_UNDER = 3'b000,
    FILL_EMPTY = 3'b001,
    FILL_LOW   = 3'b010,
    FILL_READY = 3'b011,
    FILL_HALF  = 3'b100,
    FILL_HIGH  = 3'b101,
    FILL_FULL  = 3'b110,
    FILL_OVER  = 3'b111
  } fill_e;

  typedef struct packed {
    logic              wrStb;
    logic [ADDR_W-1:0] wrAddr;
    logic              rdStb;
    logic [ADDR_W-1:0] rdAddr;
  } stb_t;

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/ancSync2.sv
module ancSync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk) begin
    stage1 <= d;
    q      <= stage1;
  end
endmodule

// File: rtl/ancFifoCtrl.sv
module ancFifoCtrl
  import ancFifoPkg::*;
#(
  parameter int LOW_MARK  = 32,
  parameter int HIGH_MARK = (1 << ADDR_W) - 32
) (
  input  logic  wrClk,
  input  logic  fifoRstN,
  input  logic  wrEnN,
  input  logic  rdClk,
  input  logic  rdEnN,
  output stb_t  stb,
  output fill_e fillCode
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] LVL_FULL = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] LVL_HALF = PTR_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] LVL_HIGH = PTR_W'(HIGH_MARK);
  localparam logic [PTR_W-1:0] LVL_LOW  = PTR_W'(LOW_MARK);

  // write-clock domain state
  logic [PTR_W-1:0] wrPtr, wrGray, rdGraySyncW, rdPtrW, level;
  logic overrun, full, wrGo;
  logic [0:0] underSyncW;

  // read-clock domain state
  logic [PTR_W-1:0] rdPtr, rdGray, wrGraySyncR;
  logic underrun, empty, rdGo;
  logic [0:0] rdRstN;

  ancSync2 #(.W(1))     uRstSync  (.clk(rdClk), .d(fifoRstN),  .q(rdRstN));
  ancSync2 #(.W(PTR_W)) uWrToRd   (.clk(rdClk), .d(wrGray),    .q(wrGraySyncR));
  ancSync2 #(.W(PTR_W)) uRdToWr   (.clk(wrClk), .d(rdGray),    .q(rdGraySyncW));
  ancSync2 #(.W(1))     uUnderSync(.clk(wrClk), .d(underrun),  .q(underSyncW));

  assign rdPtrW = gray2bin(rdGraySyncW);
  assign level  = wrPtr - rdPtrW;
  assign full   = (level == LVL_FULL);
  assign wrGo   = !wrEnN && !full && !overrun;

  always_ff @(posedge wrClk) begin
    if (!fifoRstN) begin
      wrPtr   <= '0;
      wrGray  <= '0;
      overrun <= 1'b0;
    end else begin
      if (wrGo) begin
        wrPtr  <= wrPtr + 1'b1;
        wrGray <= bin2gray(wrPtr + 1'b1);
      end
      if (!wrEnN && full) overrun <= 1'b1;
    end
  end

  always_ff @(posedge wrClk) begin
    if (!fifoRstN)                  fillCode <= FILL_EMPTY;
    else if (overrun)               fillCode <= FILL_OVER;
    else if (underSyncW[0])         fillCode <= FILL_UNDER;
    else if (level == '0)           fillCode <= FILL_EMPTY;
    else if (level <= LVL_LOW)      fillCode <= FILL_LOW;
    else if (level < LVL_HALF)      fillCode <= FILL_READY;
    else if (level < LVL_HIGH)      fillCode <= FILL_HALF;
    else if (level < LVL_FULL)      fillCode <= FILL_HIGH;
    else                            fillCode <= FILL_FULL;
  end

  assign empty = (rdGray == wrGraySyncR);
  assign rdGo  = !rdEnN && !empty;

  always_ff @(posedge rdClk) begin
    if (!rdRstN[0]) begin
      rdPtr    <= '0;
      rdGray   <= '0;
      underrun <= 1'b0;
    end else begin
      if (rdGo) begin
        rdPtr  <= rdPtr + 1'b1;
        rdGray <= bin2gray(rdPtr + 1'b1);
      end
      if (!rdEnN && empty) underrun <= 1'b1;
    end
  end

  assign stb.wrStb  = wrGo;
  assign stb.wrAddr = wrPtr[ADDR_W-1:0];
  assign stb.rdStb  = rdGo;
  assign stb.rdAddr = rdPtr[ADDR_W-1:0];

  // rdRstN also gates the read-data register in the store
endmodule

// File: rtl/ancFifoStore.sv
module ancFifoStore
  import ancFifoPkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  stb_t              stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) mem[stb.wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (!rdRstN)        rdData <= '0;
    else if (stb.rdStb) rdData <= mem[stb.rdAddr];
  end
endmodule

// File: rtl/ancFifo.sv
module ancFifo
  import ancFifoPkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              wrClk,
  input  logic              fifoRstN,
  input  logic              wrEnN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdEnN,
  output logic [DATA_W-1:0] rdData,
  output logic [2:0]        fillCode
);
  stb_t  stb;
  fill_e fillState;
  logic [0:0] rdRstN;

  ancSync2 #(.W(1)) uRdRst (.clk(rdClk), .d(fifoRstN), .q(rdRstN));

  ancFifoCtrl uCtrl (
    .wrClk(wrClk), .fifoRstN(fifoRstN), .wrEnN(wrEnN),
    .rdClk(rdClk), .rdEnN(rdEnN), .stb(stb), .fillCode(fillState)
  );

  ancFifoStore #(.DATA_W(DATA_W)) uStore (
    .wrClk(wrClk), .rdClk(rdClk), .rdRstN(rdRstN[0]),
    .stb(stb), .wrData(wrData), .rdData(rdData)
  );

  assign fillCode = fillState;
endmodule

// File: rtl/ancFifoChecker.sv
module ancFifoChecker #(
  parameter int DATA_W = 10
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              fifoRstN,
  input logic              wrEnN,
  input logic              rdEnN,
  input logic [DATA_W-1:0] rdData,
  input logic [2:0]        fillCode,
  input logic              wrStbObs
);
  assert_overrun_sticky_R7: assert property (@(posedge wrClk) disable iff (!fifoRstN)
    fillCode == 3'b111 |=> fillCode == 3'b111);

  assert_overrun_needs_write_R7: assert property (@(posedge wrClk) disable iff (!fifoRstN)
    (fillCode != 3'b111 && wrEnN && $past(wrEnN)) |=> fillCode != 3'b111);

  assert_underrun_sticky_R8: assert property (@(posedge wrClk) disable iff (!fifoRstN)
    fillCode == 3'b000 |=> (fillCode == 3'b000 || fillCode == 3'b111));

  assert_read_hold_R4: assert property (@(posedge rdClk) disable iff (!fifoRstN)
    rdEnN |=> $stable(rdData));

  assert_no_write_idle_R3: assert property (@(posedge wrClk) disable iff (!fifoRstN)
    wrEnN |-> !wrStbObs);
endmodule

bind ancFifo ancFifoChecker #(.DATA_W(DATA_W)) uChk (
  .wrClk(wrClk), .rdClk(rdClk), .fifoRstN(fifoRstN), .wrEnN(wrEnN),
  .rdEnN(rdEnN), .rdData(rdData), .fillCode(fillCode), .wrStbObs(stb.wrStb)
);

// File: tb/sim_ancFifo.sv
module sim_ancFifo;
  logic       wrClk = 1'b0;
  logic       rdClk = 1'b0;
  logic       fifoRstN = 1'b0;
  logic       wrEnN = 1'b1;
  logic       rdEnN = 1'b1;
  logic [9:0] wrData = '0;
  logic [9:0] rdData;
  logic [2:0] fillCode;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  logic [9:0] expQ[$];
  bit modelOver = 0;
  logic [9:0] seed = 10'h055;

  always #10 wrClk = ~wrClk;
  always #13 rdClk = ~rdClk;

  ancFifo u0 (
    .wrClk(wrClk), .fifoRstN(fifoRstN), .wrEnN(wrEnN), .wrData(wrData),
    .rdClk(rdClk), .rdEnN(rdEnN), .rdData(rdData), .fillCode(fillCode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wrClk);
    repeat (2) @(negedge rdClk);
    repeat (4) @(negedge wrClk);
  endtask

  task automatic doReset();
    @(negedge wrClk) fifoRstN = 1'b0;
    repeat (8) @(negedge wrClk);
    fifoRstN = 1'b1;
    expQ.delete();
    modelOver = 0;
    settle();
  endtask

  task automatic checkCode(input logic [2:0] exp, input string req);
    @(negedge wrClk);
    check(fillCode === exp, req, fillCode, exp);
  endtask

  task automatic writeWords(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrEnN = 1'b0;
      seed = seed * 10'd5 + 10'd17;
      wrData = seed;
      if (modelOver) ;
      else if (expQ.size() == 1024) modelOver = 1;
      else expQ.push_back(seed);
    end
    @(negedge wrClk) wrEnN = 1'b1;
    settle();
  endtask

  task automatic readWords(input int n, input string req);
    logic [9:0] e;
    @(negedge rdClk) rdEnN = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge rdClk);
      @(negedge rdClk);
      if (i == n - 1) rdEnN = 1'b1;
      e = expQ.pop_front();
      check(rdData === e, req, rdData, e);
    end
    settle();
  endtask

  // R1: reset state
  task automatic tReset();
    doReset();
    checkCode(3'b001, "R1");
    @(negedge rdClk);
    check(rdData === 10'h0, "R1", rdData, 0);
  endtask

  // R5 / R2: single word
  task automatic tSingle();
    writeWords(1);
    checkCode(3'b010, "R5");
    readWords(1, "R2");
    checkCode(3'b001, "R5");
  endtask

  // R5: the 32/33 boundary
  task automatic tLowEdge();
    writeWords(32);
    checkCode(3'b010, "R5");
    writeWords(1);
    checkCode(3'b011, "R5");
  endtask

  // R3: idle write cycles with changing data
  task automatic tWriteIdle();
    for (int i = 0; i < 10; i++) begin
      @(negedge wrClk);
      wrEnN = 1'b1;
      wrData = 10'(i * 37 + 1);
    end
    settle();
    checkCode(3'b011, "R3");
  endtask

  // R4: read pause holds data and pointer
  task automatic tReadPause();
    logic [9:0] held;
    readWords(1, "R2");
    held = rdData;
    repeat (6) @(negedge rdClk);
    check(rdData === held, "R4", rdData, held);
    readWords(2, "R4");
    checkCode(3'b010, "R5");
  endtask

  // R6: upper thresholds (30 words held on entry)
  task automatic tUpperEdges();
    writeWords(481);
    checkCode(3'b011, "R5");
    writeWords(1);
    checkCode(3'b100, "R6");
    writeWords(479);
    checkCode(3'b100, "R6");
    writeWords(1);
    checkCode(3'b101, "R6");
    writeWords(31);
    checkCode(3'b101, "R6");
    writeWords(1);
    checkCode(3'b110, "R6");
  endtask

  // R7 / R9: overrun, drain, then underrun on top
  task automatic tOverrun();
    writeWords(1);
    checkCode(3'b111, "R7");
    check(expQ.size() == 1024, "R7", expQ.size(), 1024);
    readWords(1024, "R7");
    checkCode(3'b111, "R7");
    @(negedge rdClk) rdEnN = 1'b0;
    @(negedge rdClk) rdEnN = 1'b1;
    settle();
    checkCode(3'b111, "R9");
  endtask

  // R10: reset discards, fresh data first
  task automatic tFresh();
    doReset();
    checkCode(3'b001, "R10");
    writeWords(3);
    readWords(3, "R10");
  endtask

  // R8: underrun sticky
  task automatic tUnderrun();
    logic [9:0] held;
    held = rdData;
    @(negedge rdClk) rdEnN = 1'b0;
    @(negedge rdClk) rdEnN = 1'b1;
    check(rdData === held, "R8", rdData, held);
    settle();
    checkCode(3'b000, "R8");
    writeWords(2);
    checkCode(3'b000, "R8");
    doReset();
    checkCode(3'b001, "R1");
  endtask

  initial begin
    tReset();
    tSingle();
    tLowEdge();
    tWriteIdle();
    tReadPause();
    tUpperEdges();
    tOverrun();
    tFresh();
    tUnderrun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge wrClk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule